// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and memory. It takes processor stores one word at a time and holds them so the processor keeps running while memory is busy. Each slot holds one aligned block of several words, along with a flag for every byte saying whether that byte holds stored data. Every new store is compared with all occupied slots. When its block is already held, its bytes are folded into that slot and no new slot is taken. When its block is not held, an empty slot is claimed.

Slots are written out to memory one at a time, oldest first, over a write port with a valid/acknowledge handshake. Each memory write carries the block address, the whole block of data and the byte mask built up from all the stores merged into that slot. The oldest slot is the one being offered to memory, so it no longer accepts merges. A store that matches no mergeable slot while every slot is taken is held off until a slot drains.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `mw_valid` is 0 and `st_ready` is 1.
- R2: A store whose block matches no mergeable slot claims a new slot. Occupied slots are offered on the memory port in the order they were claimed, and `mw_valid` is 1 exactly while at least one slot is occupied.
- R3: A store whose block (`st_addr` without its low word-select bits) equals that of an occupied slot other than the oldest merges into that slot, and the slot's byte mask becomes the OR of the old mask and the store's lanes.
- R4: When a merge overlaps bytes already held, the newer store's bytes replace the older ones. Data bytes whose mask bit is 0 are unspecified.
- R5: The oldest slot, which is the one presented on the memory port, never merges. A store to its block claims a new slot instead.
- R6: `st_ready` is 1 when a slot is free or the store's block matches a mergeable slot. It is 0 when every slot is occupied and there is no such match. An acknowledge in the same cycle does not raise `st_ready`.
- R7: While `mw_valid` is 1 and `mw_ack` is 0, `mw_addr`, `mw_data` and `mw_mask` hold their values. The oldest slot is freed on the clock edge where `mw_ack` is 1.
- R8: Byte-enable bit b of a store to word w (`st_addr[1:0]` = w) maps to mask bit 4w+b and to data bits [32w+8b +: 8] of the block.
- R9: On a clock edge where an acknowledge frees the oldest slot and a store claims a new slot, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted on this edge when valid |
| st_addr | input | 30 | Word address of the store; the low 2 bits select the word in the block |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Byte enables of the store word |
| mw_valid | output | 1 | Oldest slot offered to memory |
| mw_ack | input | 1 | Memory has taken the offered block |
| mw_addr | output | 28 | Block address of the offered slot |
| mw_data | output | 128 | Block data of the offered slot |
| mw_mask | output | 16 | Byte mask of the offered slot |

## Verification
The bench uses the default parameters: four slots of four 32-bit words and 30-bit word addresses. With only four slots, a few stores are enough to fill the buffer, so stalls, merges into a full buffer and an acknowledge in the same cycle as a new claim all come up in directed sequences. Limiting the random stores to three blocks keeps merges into the younger slots and clashes with the oldest slot frequent.

// File: rtl/mwb_pkg.sv
// Package: shared defaults for the coalescing store buffer.
// Assumes: the top and the bench read their default sizes from here.
package mwb_pkg;
    localparam int DEF_SLOTS  = 4;   // number of block slots
    localparam int DEF_WORDS  = 4;   // words per block
    localparam int DEF_WORD_W = 32;  // bits per word
    localparam int DEF_ADDR_W = 30;  // word-address width

    // Slot occupancy state
    typedef enum logic {SLOT_EMPTY = 1'b0, SLOT_HELD = 1'b1} slot_state_e;
endpackage

// File: rtl/mwb_lanes.sv
// Module: spreads one store word across the lanes of a block.
// Assumes: WORDS >= 2 and a power of two; WORD_W is a multiple of 8.
module mwb_lanes #(
    parameter  int WORDS  = 4,
    parameter  int WORD_W = 32,
    localparam int BYTES  = WORD_W / 8,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BLK_B  = WORDS * BYTES,
    localparam int BLK_W  = WORDS * WORD_W
) (
    input  logic [WSEL_W-1:0] word_sel,
    input  logic [BYTES-1:0]  be,
    input  logic [WORD_W-1:0] wdata,
    output logic [BLK_B-1:0]  lane_mask,
    output logic [BLK_W-1:0]  lane_data
);
    // One lane group per word: enables only in the selected word, data copied everywhere
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign lane_mask[w*BYTES +: BYTES]   = (word_sel == WSEL_W'(w)) ? be : '0;
        assign lane_data[w*WORD_W +: WORD_W] = wdata;
    end
endmodule

// File: rtl/mwb_slot.sv
// Module: storage for one block slot (address, data, byte mask, state).
// Assumes: load and merge are never high together; release frees the slot.
module mwb_slot #(
    parameter int BLK_AW = 28,
    parameter int BLK_B  = 16,
    localparam int BLK_W = BLK_B * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              merge,
    input  logic              release_i,
    input  logic [BLK_AW-1:0] blk_in,
    input  logic [BLK_B-1:0]  lane_mask,
    input  logic [BLK_W-1:0]  lane_data,
    output logic              held,
    output logic [BLK_AW-1:0] blk,
    output logic [BLK_W-1:0]  data,
    output logic [BLK_B-1:0]  mask
);
    import mwb_pkg::*;

    slot_state_e state;

    assign held = (state == SLOT_HELD);

    // Track occupancy: claimed on load, freed on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SLOT_EMPTY;
        end else if (load) begin
            state <= SLOT_HELD;
        end else if (release_i) begin
            state <= SLOT_EMPTY;
        end
    end

    // Block address and mask: restart on load, accumulate on merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk  <= '0;
            mask <= '0;
        end else if (load) begin
            blk  <= blk_in;
            mask <= lane_mask;
        end else if (merge) begin
            mask <= mask | lane_mask;
        end
    end

    // Byte data: each enabled lane takes the newest store byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else begin
            for (int i = 0; i < BLK_B; i++) begin
                if ((load || merge) && lane_mask[i]) begin
                    data[i*8 +: 8] <= lane_data[i*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/mwb_match.sv
// Module: compares a store's block with every held slot except the oldest.
// Assumes: at most one slot can match; the lowest index wins if several do.
module mwb_match #(
    parameter  int SLOTS  = 4,
    parameter  int BLK_AW = 28,
    localparam int PTR_W  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]             slot_held,
    input  logic [SLOTS-1:0][BLK_AW-1:0] slot_blk,
    input  logic [PTR_W-1:0]             head,
    input  logic [BLK_AW-1:0]            probe_blk,
    output logic [SLOTS-1:0]             hit_vec,
    output logic                         hit,
    output logic [PTR_W-1:0]             hit_idx
);
    // One comparator per slot; the slot offered to memory is left out
    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign hit_vec[i] = slot_held[i] && (head != PTR_W'(i)) &&
                            (slot_blk[i] == probe_blk);
    end

    assign hit = |hit_vec;

    // Encode the matching slot index
    always_comb begin
        hit_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = PTR_W'(i);
        end
    end
endmodule

// File: rtl/mwb_order.sv
// Module: claim and drain pointers plus occupancy count, oldest first.
// Assumes: push is never high when full; pop is never high when empty.
module mwb_order #(
    parameter  int SLOTS = 4,
    localparam int PTR_W = $clog2(SLOTS),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [OCC_W-1:0] occ
);
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and adjust occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= step(tail);
            if (pop)  head <= step(head);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/merge_write_buffer.sv
// Module: coalescing store buffer between a write-through cache and memory.
// Stores merge into a held block slot that has the same block address; the oldest
// slot drains to memory through a valid/ack port and cannot merge.
// Assumes: SLOTS >= 2, WORDS >= 2 and powers of two; st_addr is a word address.
module merge_write_buffer #(
    parameter  int SLOTS  = mwb_pkg::DEF_SLOTS,
    parameter  int WORDS  = mwb_pkg::DEF_WORDS,
    parameter  int WORD_W = mwb_pkg::DEF_WORD_W,
    parameter  int ADDR_W = mwb_pkg::DEF_ADDR_W,
    localparam int BYTES  = WORD_W / 8,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BLK_AW = ADDR_W - WSEL_W,
    localparam int BLK_B  = WORDS * BYTES,
    localparam int BLK_W  = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_data,
    input  logic [BYTES-1:0]  st_be,
    output logic              mw_valid,
    input  logic              mw_ack,
    output logic [BLK_AW-1:0] mw_addr,
    output logic [BLK_W-1:0]  mw_data,
    output logic [BLK_B-1:0]  mw_mask
);
    localparam int PTR_W = $clog2(SLOTS);
    localparam int OCC_W = PTR_W + 1;

    logic [BLK_AW-1:0] st_blk;
    logic [BLK_B-1:0]  lane_mask;
    logic [BLK_W-1:0]  lane_data;

    logic [SLOTS-1:0]             slot_held;
    logic [SLOTS-1:0][BLK_AW-1:0] slot_blk;
    logic [SLOTS-1:0][BLK_W-1:0]  slot_data;
    logic [SLOTS-1:0][BLK_B-1:0]  slot_mask;

    logic [SLOTS-1:0] hit_vec;
    logic             hit;
    logic [PTR_W-1:0] hit_idx;
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    logic [OCC_W-1:0] occ;

    logic full;
    logic accept;
    logic push;
    logic pop;

    assign st_blk = st_addr[ADDR_W-1:WSEL_W];

    mwb_lanes #(.WORDS(WORDS), .WORD_W(WORD_W)) u_lanes (
        .word_sel  (st_addr[WSEL_W-1:0]),
        .be        (st_be),
        .wdata     (st_data),
        .lane_mask (lane_mask),
        .lane_data (lane_data)
    );

    mwb_match #(.SLOTS(SLOTS), .BLK_AW(BLK_AW)) u_match (
        .slot_held (slot_held),
        .slot_blk  (slot_blk),
        .head      (head),
        .probe_blk (st_blk),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    mwb_order #(.SLOTS(SLOTS)) u_order (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .occ   (occ)
    );

    // Handshake decisions for this cycle
    always_comb begin
        full     = (occ == OCC_W'(SLOTS));
        st_ready = hit || !full;
        accept   = st_valid && st_ready;
        push     = accept && !hit;
        mw_valid = (occ != '0);
        pop      = mw_valid && mw_ack;
    end

    // One slot per entry, each steered by claim, merge and drain selects
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        mwb_slot #(.BLK_AW(BLK_AW), .BLK_B(BLK_B)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (push && (tail == PTR_W'(i))),
            .merge     (accept && hit && (hit_idx == PTR_W'(i))),
            .release_i (pop && (head == PTR_W'(i))),
            .blk_in    (st_blk),
            .lane_mask (lane_mask),
            .lane_data (lane_data),
            .held      (slot_held[i]),
            .blk       (slot_blk[i]),
            .data      (slot_data[i]),
            .mask      (slot_mask[i])
        );
    end

    // Memory port shows the oldest slot
    always_comb begin
        mw_addr = slot_blk[head];
        mw_data = slot_data[head];
        mw_mask = slot_mask[head];
    end
endmodule

// File: rtl/mwb_checker.sv
// Module: temporal checks on the coalescing store buffer, bound to its top.
// Assumes: it observes internal occupancy, head pointer and match vector.
module mwb_checker #(
    parameter  int SLOTS  = 4,
    parameter  int BLK_AW = 28,
    parameter  int BLK_W  = 128,
    parameter  int BLK_B  = 16,
    localparam int PTR_W  = $clog2(SLOTS),
    localparam int OCC_W  = PTR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              mw_valid,
    input logic              mw_ack,
    input logic [BLK_AW-1:0] mw_addr,
    input logic [BLK_W-1:0]  mw_data,
    input logic [BLK_B-1:0]  mw_mask,
    input logic [SLOTS-1:0]  hit_vec,
    input logic              hit,
    input logic [PTR_W-1:0]  head,
    input logic [OCC_W-1:0]  occ
);
    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (occ == '0) && st_ready && !mw_valid);

    assert_claim_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !hit && !(mw_valid && mw_ack)) |=> (occ == $past(occ) + 1'b1));

    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_oldest_not_merged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != '0) |-> !hit_vec[head]);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(SLOTS));

    assert_free_slot_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < OCC_W'(SLOTS)) |-> st_ready);

    assert_offer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ack) |=> mw_valid && $stable(mw_addr) && $stable(mw_mask) && $stable(mw_data));

    assert_drain_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && mw_ack && !(st_valid && st_ready && !hit)) |=> (occ == $past(occ) - 1'b1));
endmodule

bind merge_write_buffer mwb_checker #(
    .SLOTS(SLOTS), .BLK_AW(BLK_AW), .BLK_W(BLK_W), .BLK_B(BLK_B)
) u_mwb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .mw_valid (mw_valid),
    .mw_ack   (mw_ack),
    .mw_addr  (mw_addr),
    .mw_data  (mw_data),
    .mw_mask  (mw_mask),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .head     (head),
    .occ      (occ)
);

// File: tb/merge_write_buffer_test.sv
// Bench: behavioural queue model of the store buffer, compared every cycle,
// plus directed sequences for stalls, merges, overlap and ordering.
module merge_write_buffer_test;
    localparam int SLOTS  = 4;
    localparam int ADDR_W = 30;
    localparam int BLK_AW = 28;
    localparam int BLK_W  = 128;
    localparam int BLK_B  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic              st_ready;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [31:0]       st_data = '0;
    logic [3:0]        st_be = '0;
    logic              mw_valid;
    logic              mw_ack = 1'b0;
    logic [BLK_AW-1:0] mw_addr;
    logic [BLK_W-1:0]  mw_data;
    logic [BLK_B-1:0]  mw_mask;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    merge_write_buffer uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .mw_valid(mw_valid), .mw_ack(mw_ack), .mw_addr(mw_addr),
        .mw_data(mw_data), .mw_mask(mw_mask)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [BLK_AW-1:0] blk;
        logic [BLK_W-1:0]  d;
        logic [BLK_B-1:0]  m;
    } ent_t;

    ent_t q[$];

    task automatic chk(input string req, input string what,
                       input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [BLK_W-1:0] spread(input logic [BLK_B-1:0] m);
        logic [BLK_W-1:0] r;
        for (int i = 0; i < BLK_B; i++) r[i*8 +: 8] = {8{m[i]}};
        return r;
    endfunction

    // R8 lane mapping: enable bit b of word w goes to byte 4w+b
    function automatic ent_t put_bytes(input ent_t e, input logic [1:0] w,
                                       input logic [3:0] be, input logic [31:0] d);
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                e.m[w*4 + b] = 1'b1;
                e.d[(w*4 + b)*8 +: 8] = d[b*8 +: 8];
            end
        end
        return e;
    endfunction

    // Mergeable match: any held entry except the oldest (R3, R5)
    function automatic int find_hit(input logic [BLK_AW-1:0] blk);
        for (int i = 1; i < q.size(); i++) if (q[i].blk == blk) return i;
        return -1;
    endfunction

    function automatic bit model_ready();
        return (find_hit(st_addr[ADDR_W-1:2]) >= 0) || (q.size() < SLOTS);
    endfunction

    // Model update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
        end else begin
            int   h;
            int   n0;
            bit   rdy;
            ent_t e;
            n0  = q.size();
            h   = find_hit(st_addr[ADDR_W-1:2]);
            rdy = (h >= 0) || (n0 < SLOTS);
            if (st_valid && rdy) begin
                if (h >= 0) begin
                    q[h] = put_bytes(q[h], st_addr[1:0], st_be, st_data);
                end else begin
                    e.blk = st_addr[ADDR_W-1:2];
                    e.d   = '0;
                    e.m   = '0;
                    q.push_back(put_bytes(e, st_addr[1:0], st_be, st_data));
                end
            end
            if (mw_ack && n0 > 0) void'(q.pop_front());
        end
    end

    // Cycle compare, away from the edge and after inputs settle
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R6", "st_ready", st_ready, model_ready());
            chk("R2", "mw_valid", mw_valid, q.size() > 0);
            if (q.size() > 0) begin
                chk("R7", "mw_addr", mw_addr, q[0].blk);
                chk("R3", "mw_mask", mw_mask, q[0].m);
                chk("R4", "mw_data", mw_data & spread(q[0].m), q[0].d & spread(q[0].m));
            end
        end
    end

    task automatic put(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        #2;
        while (!st_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        st_valid = 1'b0;
        #2;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: empty after reset
        chk("R1", "mw_valid after reset", mw_valid, 1'b0);
        chk("R1", "st_ready after reset", st_ready, 1'b1);

        // R8: word 2 of block 0x10, enables 0101
        put(30'h42, 32'hA1B2C3D4, 4'b0101);
        idle();
        chk("R8", "mask lanes", mw_mask, 16'h0500);
        chk("R8", "byte 8", mw_data[71:64], 8'hD4);
        chk("R8", "byte 10", mw_data[87:80], 8'hB2);
        chk("R2", "first block", mw_addr, 28'h10);

        // R5: same block as the offered slot claims a new slot
        put(30'h40, 32'h11111111, 4'hF);
        // R3: merge into that younger slot
        put(30'h41, 32'h22222222, 4'hF);
        put(30'h80, 32'h33333333, 4'hF);
        // R4: overlapping byte, newer wins
        put(30'h41, 32'h000000EE, 4'b0001);
        put(30'hC0, 32'h44444444, 4'hF);
        idle();
        chk("R5", "offered slot unchanged mask", mw_mask, 16'h0500);

        // R6: full and no match stalls
        @(negedge clk);
        st_valid = 1'b1; st_addr = 30'h100; st_data = 32'h55555555; st_be = 4'hF;
        #2;
        chk("R6", "stall when full", st_ready, 1'b0);
        @(negedge clk);
        #2;
        chk("R6", "stall holds", st_ready, 1'b0);
        // R6: full but matching a mergeable slot is accepted
        put(30'h43, 32'h66666666, 4'hF);
        // R6: acknowledge in same cycle does not raise ready
        @(negedge clk);
        st_addr = 30'h100; st_data = 32'h55555555; st_be = 4'hF;
        mw_ack = 1'b1;
        #2;
        chk("R6", "ready during ack", st_ready, 1'b0);
        @(negedge clk);
        mw_ack = 1'b0;
        #2;
        chk("R7", "slot freed on ack", st_ready, 1'b1);
        @(posedge clk);
        idle();
        // R5/R4/R3: the younger copy of block 0x10 is now oldest
        chk("R5", "second slot addr", mw_addr, 28'h10);
        chk("R3", "merged mask", mw_mask, 16'hF0FF);
        chk("R4", "merged word 1", mw_data[63:32], 32'h222222EE);

        // drain one: block 0x20 offered, buffer has 0x20,0x30,0x40
        @(negedge clk); mw_ack = 1'b1;
        @(negedge clk); mw_ack = 1'b0;
        #2;
        chk("R2", "order third", mw_addr, 28'h20);
        // R9: ack and claim in one cycle
        @(negedge clk);
        mw_ack = 1'b1; st_valid = 1'b1; st_addr = 30'h140; st_data = 32'h77777777; st_be = 4'hF;
        @(negedge clk);
        mw_ack = 1'b0; st_valid = 1'b0;
        #2;
        chk("R9", "head after ack", mw_addr, 28'h30);
        @(negedge clk); mw_ack = 1'b1;
        @(negedge clk); mw_ack = 1'b0;
        #2;
        chk("R2", "order D", mw_addr, 28'h40);
        @(negedge clk); mw_ack = 1'b1;
        @(negedge clk); mw_ack = 1'b0;
        #2;
        chk("R9", "claimed during ack", mw_addr, 28'h50);
        chk("R9", "claimed data", mw_data[31:0], 32'h77777777);

        // Random traffic over three blocks; the model checks every cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            st_valid = ($urandom % 2) == 0;
            st_addr  = 30'h40 + ADDR_W'($urandom % 12);
            st_be    = 4'($urandom);
            st_data  = $urandom;
            mw_ack   = ($urandom % 3) == 0;
        end

        // Drain everything
        @(negedge clk);
        st_valid = 1'b0;
        mw_ack = 1'b1;
        repeat (8) @(negedge clk);
        mw_ack = 1'b0;
        #2;
        chk("R2", "empty after drain", mw_valid, 1'b0);
        chk("R6", "ready after drain", st_ready, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule